// File: doc/BRIEF.md
# Inter-Processor Mailbox with Doorbells

This block connects a host processor to an I/O processor through a small set of memory-mapped registers. To post work, the host stores the physical address of a command structure in the request-pointer register. It then sets a doorbell bit in a shared flag register. That bit raises an interrupt toward the I/O processor. When the command is done, the I/O processor copies the request address into the reply-pointer register. It then sets the reply pattern 0x14 in the flag register, which interrupts the host. Neither side writes the flag register directly. Each side sets flags through one offset and clears them through another, so that updates from both sides in the same cycle all take effect.

Each processor has its own simple register port: a one-cycle request strobe with write enable, address and write data. Reads return data one cycle after the request, marked by a valid pulse. The 0x400-byte register window repeats across a 0x6000-byte aperture. Addresses outside the aperture, and word offsets inside the window that map to no register, read as zero.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Byte offset 0x0 holds the request pointer. A write from either port replaces it, and a read returns the full word.
- R3: Byte offset 0x8 holds the reply pointer. A write from either port replaces it, and a read returns the full word.
- R4: A write to byte offset 0x4 sets each flag bit whose write-data bit is 1 and leaves every other flag bit unchanged. A read of 0x4 returns the flag register.
- R5: A write to byte offset 0xC clears each flag bit whose write-data bit is 1 and leaves the others unchanged. A read of 0xC also returns the flag register.
- R6: The I/O processor interrupt `iop_irq_o` is high exactly while flag bit 0 (request ready) is set.
- R7: The host interrupt `hst_irq_o` is high exactly while flag bit 2 or flag bit 4 is set. These are the two bits of the reply pattern 0x14.
- R8: When both ports write the same pointer register in the same cycle, the host's data is kept.
- R9: When both ports write flags in the same cycle, all their clear masks are applied first and then all their set masks. A bit that one side sets while the other clears it ends up set.
- R10: Only address bits [9:2] select the register, so an address plus any multiple of 0x400 below 0x6000 reaches the same register.
- R11: A word offset with no register, an address at or above 0x6000, or an address with bits [1:0] not zero reads as zero, and writes to it change nothing.
- R12: Both ports see the same registers, so a value written from one port is read back unchanged from the other.
- R13: A read returns data and a one-cycle valid pulse in the cycle after the request. A write produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hst_req_i | input | 1 | Host port access strobe |
| hst_we_i | input | 1 | Host port write enable |
| hst_addr_i | input | ADDR_W | Host port byte address |
| hst_wdata_i | input | DATA_W | Host port write data |
| hst_rdata_o | output | DATA_W | Host port read data |
| hst_rvalid_o | output | 1 | Host port read data valid |
| iop_req_i | input | 1 | I/O processor port access strobe |
| iop_we_i | input | 1 | I/O processor port write enable |
| iop_addr_i | input | ADDR_W | I/O processor port byte address |
| iop_wdata_i | input | DATA_W | I/O processor port write data |
| iop_rdata_o | output | DATA_W | I/O processor port read data |
| iop_rvalid_o | output | 1 | I/O processor port read data valid |
| hst_irq_o | output | 1 | Reply-ready interrupt to the host |
| iop_irq_o | output | 1 | Request-ready interrupt to the I/O processor |

## Verification
The assertions run every cycle. They check the flag register: set bits always land, cleared bits drop unless a set on the same bit overrides them, and the flags hold when nothing writes them. They also check that the host wins pointer collisions, that each decoder selects at most one register, and that every rising interrupt follows a set write of a matching bit. The bench scenarios cover the rest. They show the full doorbell-and-reply handshake between the two ports, the aliasing of the window and the aperture limit, and zero reads from unmapped and misaligned addresses. They also show that the host interrupt stays high while one reply bit is still set.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  // word indices inside the 0x400-byte window
  localparam int unsigned WI_REQ   = 0;  // 0x0
  localparam int unsigned WI_FSET  = 1;  // 0x4
  localparam int unsigned WI_REPLY = 2;  // 0x8
  localparam int unsigned WI_FCLR  = 3;  // 0xC

  localparam int unsigned BIT_REQ_RDY  = 0;
  localparam int unsigned BIT_RPLY_LO  = 2;
  localparam int unsigned BIT_RPLY_HI  = 4;

  typedef struct packed {
    logic req;
    logic fset;
    logic rply;
    logic fclr;
  } reg_hit_t;
endpackage

// File: rtl/ipc_port_dec.sv
module ipc_port_dec
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned WIN_BITS = 10,
  parameter int unsigned SPAN     = 'h6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_hit_t          hit_o
);
  localparam int unsigned WORD_W = WIN_BITS - 2;

  logic [WORD_W-1:0] word;
  logic              in_span;

  assign word    = addr_i[WIN_BITS-1:2];
  assign in_span = (addr_i < ADDR_W'(SPAN)) && (addr_i[1:0] == 2'b00) && req_i;

  always_comb begin
    hit_o      = '0;
    hit_o.req  = in_span && (word == WORD_W'(WI_REQ));
    hit_o.fset = in_span && (word == WORD_W'(WI_FSET));
    hit_o.rply = in_span && (word == WORD_W'(WI_REPLY));
    hit_o.fclr = in_span && (word == WORD_W'(WI_FCLR));
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)) else $error("decoder selected two registers"); // R11
  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (hit_o == '0)) else $error("hit without request"); // R11
endmodule

// File: rtl/ipc_ptr_reg.sv
module ipc_ptr_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_we_i,
  input  logic [DATA_W-1:0] hst_d_i,
  input  logic              iop_we_i,
  input  logic [DATA_W-1:0] iop_d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (hst_we_i) q_o <= hst_d_i;   // host has priority
    else if (iop_we_i) q_o <= iop_d_i;
  end

  AST_HOST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_we_i && iop_we_i) |=> (q_o == $past(hst_d_i))) else $error("host lost collision"); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hst_we_i && !iop_we_i) |=> $stable(q_o)) else $error("pointer changed unwritten"); // R2
endmodule

// File: rtl/ipc_flag_reg.sv
module ipc_flag_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_h_i,
  input  logic [DATA_W-1:0] set_i_i,
  input  logic [DATA_W-1:0] clr_h_i,
  input  logic [DATA_W-1:0] clr_i_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] set_all, clr_all;

  assign set_all = set_h_i | set_i_i;
  assign clr_all = clr_h_i | clr_i_i;

  // clears first, then sets: a set survives a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_all) | set_all;
  end

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_all != '0) |=> ((q_o & $past(set_all)) == $past(set_all))) else $error("set bit lost"); // R4
  AST_CLR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all != '0) |=> ((q_o & $past(clr_all & ~set_all)) == '0)) else $error("clear bit lost"); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_all == '0 && clr_all == '0) |=> $stable(q_o)) else $error("flags changed unwritten"); // R9
endmodule

// File: rtl/ipc_rd_port.sv
module ipc_rd_port
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  reg_hit_t          hit_i,
  input  logic [DATA_W-1:0] req_ptr_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [DATA_W-1:0] rply_ptr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    if (hit_i.req)                     mux = req_ptr_i;
    else if (hit_i.fset || hit_i.fclr) mux = flags_i;
    else if (hit_i.rply)               mux = rply_ptr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= mux;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o) else $error("valid without read"); // R13
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned WIN_BITS = 10,
  parameter int unsigned SPAN     = 'h6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [DATA_W-1:0] hst_wdata_i,
  output logic [DATA_W-1:0] hst_rdata_o,
  output logic              hst_rvalid_o,
  input  logic              iop_req_i,
  input  logic              iop_we_i,
  input  logic [ADDR_W-1:0] iop_addr_i,
  input  logic [DATA_W-1:0] iop_wdata_i,
  output logic [DATA_W-1:0] iop_rdata_o,
  output logic              iop_rvalid_o,
  output logic              hst_irq_o,
  output logic              iop_irq_o
);
  localparam int unsigned N_PORTS = 2;  // 0: host, 1: I/O processor

  logic              req_a   [N_PORTS];
  logic              we_a    [N_PORTS];
  logic [ADDR_W-1:0] addr_a  [N_PORTS];
  logic [DATA_W-1:0] wdata_a [N_PORTS];
  logic [DATA_W-1:0] rdata_a [N_PORTS];
  logic              rvld_a  [N_PORTS];
  reg_hit_t          hit_a   [N_PORTS];
  reg_hit_t          wsel_a  [N_PORTS];
  logic [DATA_W-1:0] set_a   [N_PORTS];
  logic [DATA_W-1:0] clr_a   [N_PORTS];

  logic [DATA_W-1:0] req_ptr_q, rply_ptr_q, flags_q;

  assign req_a[0]   = hst_req_i;
  assign we_a[0]    = hst_we_i;
  assign addr_a[0]  = hst_addr_i;
  assign wdata_a[0] = hst_wdata_i;
  assign req_a[1]   = iop_req_i;
  assign we_a[1]    = iop_we_i;
  assign addr_a[1]  = iop_addr_i;
  assign wdata_a[1] = iop_wdata_i;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    ipc_port_dec #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SPAN(SPAN)
    ) u_dec (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_a[g]),
      .addr_i(addr_a[g]),
      .hit_o (hit_a[g])
    );

    assign wsel_a[g] = we_a[g] ? hit_a[g] : '0;
    assign set_a[g]  = wsel_a[g].fset ? wdata_a[g] : '0;
    assign clr_a[g]  = wsel_a[g].fclr ? wdata_a[g] : '0;

    ipc_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_i      (req_a[g] && !we_a[g]),
      .hit_i     (hit_a[g]),
      .req_ptr_i (req_ptr_q),
      .flags_i   (flags_q),
      .rply_ptr_i(rply_ptr_q),
      .rdata_o   (rdata_a[g]),
      .rvalid_o  (rvld_a[g])
    );
  end

  assign hst_rdata_o  = rdata_a[0];
  assign hst_rvalid_o = rvld_a[0];
  assign iop_rdata_o  = rdata_a[1];
  assign iop_rvalid_o = rvld_a[1];

  ipc_ptr_reg #(.DATA_W(DATA_W)) u_req_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hst_we_i(wsel_a[0].req), .hst_d_i(wdata_a[0]),
    .iop_we_i(wsel_a[1].req), .iop_d_i(wdata_a[1]),
    .q_o(req_ptr_q)
  );

  ipc_ptr_reg #(.DATA_W(DATA_W)) u_rply_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hst_we_i(wsel_a[0].rply), .hst_d_i(wdata_a[0]),
    .iop_we_i(wsel_a[1].rply), .iop_d_i(wdata_a[1]),
    .q_o(rply_ptr_q)
  );

  ipc_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_h_i(set_a[0]),
    .set_i_i(set_a[1]),
    .clr_h_i(clr_a[0]),
    .clr_i_i(clr_a[1]),
    .q_o    (flags_q)
  );

  assign iop_irq_o = flags_q[BIT_REQ_RDY];
  assign hst_irq_o = flags_q[BIT_RPLY_LO] | flags_q[BIT_RPLY_HI];

  AST_IOP_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iop_irq_o) |-> $past(set_a[0][BIT_REQ_RDY] || set_a[1][BIT_REQ_RDY]))
    else $error("iop irq rose without doorbell"); // R6
  AST_HST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hst_irq_o) |-> $past(set_a[0][BIT_RPLY_LO] || set_a[1][BIT_RPLY_LO] ||
                               set_a[0][BIT_RPLY_HI] || set_a[1][BIT_RPLY_HI]))
    else $error("host irq rose without reply"); // R7
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  localparam int AW = 15;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          hst_req_i = 0, hst_we_i = 0, iop_req_i = 0, iop_we_i = 0;
  logic [AW-1:0] hst_addr_i = '0, iop_addr_i = '0;
  logic [DW-1:0] hst_wdata_i = '0, iop_wdata_i = '0;
  logic [DW-1:0] hst_rdata_o, iop_rdata_o;
  logic          hst_rvalid_o, iop_rvalid_o, hst_irq_o, iop_irq_o;

  ipc_mailbox dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .hst_req_i(hst_req_i), .hst_we_i(hst_we_i), .hst_addr_i(hst_addr_i),
    .hst_wdata_i(hst_wdata_i), .hst_rdata_o(hst_rdata_o), .hst_rvalid_o(hst_rvalid_o),
    .iop_req_i(iop_req_i), .iop_we_i(iop_we_i), .iop_addr_i(iop_addr_i),
    .iop_wdata_i(iop_wdata_i), .iop_rdata_o(iop_rdata_o), .iop_rvalid_o(iop_rvalid_o),
    .hst_irq_o(hst_irq_o), .iop_irq_o(iop_irq_o)
  );

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] exp_h[$], exp_p[$];
  string tag_h[$], tag_p[$];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as valid pulses appear (R13)
  always @(negedge clk) begin
    if (rst_ni && hst_rvalid_o) begin
      if (exp_h.size() == 0) check("R13 host unexpected rvalid", 1, 0);
      else check(tag_h.pop_front(), hst_rdata_o, exp_h.pop_front());
    end
    if (rst_ni && iop_rvalid_o) begin
      if (exp_p.size() == 0) check("R13 iop unexpected rvalid", 1, 0);
      else check(tag_p.pop_front(), iop_rdata_o, exp_p.pop_front());
    end
  end

  task automatic op(bit port, bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    if (port == 0) begin
      hst_req_i = 1; hst_we_i = we; hst_addr_i = a; hst_wdata_i = d;
    end else begin
      iop_req_i = 1; iop_we_i = we; iop_addr_i = a; iop_wdata_i = d;
    end
    @(posedge clk); #1;
    hst_req_i = 0; hst_we_i = 0; iop_req_i = 0; iop_we_i = 0;
  endtask

  task automatic wr(bit port, logic [AW-1:0] a, logic [DW-1:0] d);
    op(port, 1'b1, a, d);
  endtask

  task automatic rd(bit port, logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    if (port == 0) begin exp_h.push_back(exp); tag_h.push_back(tag); end
    else begin exp_p.push_back(exp); tag_p.push_back(tag); end
    op(port, 1'b0, a, '0);
  endtask

  task automatic dual_wr(logic [AW-1:0] ha, logic [DW-1:0] hd,
                         logic [AW-1:0] ia, logic [DW-1:0] id);
    @(negedge clk);
    hst_req_i = 1; hst_we_i = 1; hst_addr_i = ha; hst_wdata_i = hd;
    iop_req_i = 1; iop_we_i = 1; iop_addr_i = ia; iop_wdata_i = id;
    @(posedge clk); #1;
    hst_req_i = 0; hst_we_i = 0; iop_req_i = 0; iop_we_i = 0;
  endtask

  task automatic chk_irq(logic h, logic p, string tag);
    @(negedge clk);
    check({tag, " hst_irq"}, {31'b0, hst_irq_o}, {31'b0, h});
    check({tag, " iop_irq"}, {31'b0, iop_irq_o}, {31'b0, p});
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    chk_irq(0, 0, "R1 in reset");
    @(negedge clk); rst_ni = 1;
    // R1 reset state from both ports
    rd(0, 'h0, 0, "R1 req ptr");
    rd(1, 'h4, 0, "R1 flags");
    rd(0, 'h8, 0, "R1 reply ptr");
    chk_irq(0, 0, "R1 after reset");

    // R2/R12 request pointer written by host, read by iop
    wr(0, 'h0, 32'h1234_5670);
    rd(1, 'h0, 32'h1234_5670, "R2 R12 req ptr cross read");
    // R4/R6 doorbell
    wr(0, 'h4, 32'h1);
    chk_irq(0, 1, "R6 doorbell");
    rd(0, 'h4, 32'h1, "R4 flag set");
    // R3 reply pointer from iop
    wr(1, 'h8, 32'h1234_5670);
    rd(0, 'h8, 32'h1234_5670, "R3 reply ptr");
    // R5 iop acknowledges, R7 reply pattern
    wr(1, 'hC, 32'h1);
    chk_irq(0, 0, "R5 doorbell cleared");
    wr(1, 'h4, 32'h14);
    chk_irq(1, 0, "R7 reply ready");
    rd(0, 'hC, 32'h14, "R5 read via clear offset");
    wr(0, 'hC, 32'h10);
    chk_irq(1, 0, "R7 one reply bit left");
    wr(0, 'hC, 32'h4);
    chk_irq(0, 0, "R7 reply cleared");
    // R4 zero bits leave flags unchanged
    wr(1, 'h4, 32'h100);
    wr(0, 'h4, 32'h0);
    rd(1, 'h4, 32'h100, "R4 zero write no effect");
    wr(0, 'hC, 32'h100);

    // R8 pointer collision
    dual_wr('h0, 32'hAAAA_0000, 'h0, 32'hBBBB_0000);
    rd(1, 'h0, 32'hAAAA_0000, "R8 host wins req ptr");
    dual_wr('h8, 32'hCCCC_0000, 'h8, 32'hDDDD_0000);
    rd(1, 'h8, 32'hCCCC_0000, "R8 host wins reply ptr");
    // R9 flag merges
    dual_wr('h4, 32'h1, 'hC, 32'h1);
    rd(0, 'h4, 32'h1, "R9 set beats clear");
    dual_wr('h4, 32'h2, 'h4, 32'h8);
    rd(0, 'h4, 32'hB, "R9 both sets merge");
    dual_wr('hC, 32'h3, 'h4, 32'h2);
    rd(1, 'h4, 32'hA, "R9 clear then set");
    chk_irq(0, 0, "R9 irqs after merge");

    // R10 aliasing
    wr(0, 'h1408, 32'hDEAD_0000);
    rd(1, 'h0008, 32'hDEAD_0000, "R10 alias write");
    rd(0, 'h5C04, 32'hA, "R10 alias read top copy");
    // R11 unmapped, out of aperture, misaligned
    wr(0, 'h0010, 32'hFFFF_FFFF);
    rd(0, 'h0010, 32'h0, "R11 unmapped reads zero");
    wr(1, 'h6000, 32'h5555_5555);
    rd(1, 'h6000, 32'h0, "R11 beyond aperture reads zero");
    wr(0, 'h0001, 32'h7777_7777);
    rd(0, 'h0001, 32'h0, "R11 misaligned reads zero");
    wr(1, 'h6004, 32'h1);
    chk_irq(0, 0, "R11 beyond aperture no set");
    rd(1, 'h0, 32'hAAAA_0000, "R11 req ptr untouched");
    rd(0, 'h8, 32'hDEAD_0000, "R11 reply ptr untouched");
    rd(1, 'h4, 32'hA, "R11 flags untouched");

    repeat (3) @(negedge clk);
    if (exp_h.size() != 0 || exp_p.size() != 0)
      check("R13 missing read responses", 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule